// File: doc/BRIEF.md
# Configurable Pixel Component Extractor

This block sits between a frame-buffer fetch path and a display pipeline. Each cycle it may accept one packed pixel word and split it into red, green and blue components of 8 bits each. Software sets the layout of the pixel word through four small registers. A format register gives the number of bytes in a pixel and their byte order. One select register per colour gives the bit position and bit width of that colour's field, plus a fallback value.

The path has two pipeline stages. The first stage masks the word to the pixel's byte count and reverses the byte order where needed. It also takes a copy of the three colour selects, so the configuration travels with the pixel. The second stage cuts out each field and scales it to 8 bits. Narrow fields are widened by repeating their upper bits. Wide fields give up their low bits. Outputs change only when a result is valid and hold their value in between.

Top module: `pix_chan_unpack`

## Requirements
- R1: After reset, `comp_vld` and all three component outputs are 0. The configuration is 4-byte pixels, little-endian, with red at bit 0, green at bit 8 and blue at bit 16, each 8 bits wide with a fallback of 0.
- R2: A word accepted with `pix_vld` high on a clock edge appears as `comp_vld` high after the following edge, which is a latency of two edges. `comp_vld` is low in every other cycle.
- R3: In little-endian mode the pixel bytes are used in the order they arrive. Bytes at index N and above read as zero, where N is the configured byte count.
- R4: In big-endian mode, byte i of the pixel is taken from input byte N-1-i, for i below N.
- R5: The format register is at `cfg_addr` 0. Bit 31 selects the byte order (1 = big-endian). Bits 5:3 hold the byte count minus one. Counts above 4 are clamped to 4.
- R6: The select registers are at `cfg_addr` 1 (red), 2 (green) and 3 (blue). Bits 7:0 hold the bit offset, bits 15:8 the width and bits 23:16 the fallback value. Bits at positions 32 and above read as zero.
- R7: A channel whose width is 0 outputs its fallback value.
- R8: A channel with a width from 1 to 7 places its field in the top bits of the output. Each vacant low bit then takes the field bit found by cycling down from the field's top bit.
- R9: A channel with a width of 8 or more outputs the top 8 bits of its field, which are bits offset+width-8 through offset+width-1.
- R10: A register write on an edge applies to pixels accepted on later edges. A pixel accepted on the same edge as the write, or earlier, uses the old setting.
- R11: While `comp_vld` is low, the three component outputs keep their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 format, 1 red, 2 green, 3 blue |
| cfg_wdata | input | 32 | Register write data |
| pix_vld | input | 1 | Pixel word valid |
| pix_word | input | 32 | Packed pixel word |
| comp_vld | output | 1 | Component outputs valid |
| comp_r | output | 8 | Red component |
| comp_g | output | 8 | Green component |
| comp_b | output | 8 | Blue component |

## Verification
The bench drives a pixel word every cycle and a register write on about one cycle in ten. It compares all three outputs every cycle. Each register in the design shows up at the ports within two edges:
- A wrong byte mask or byte order corrupts the components of the next valid pixel.
- A select captured from the wrong register makes the output disagree on the pixels that straddle a write.
- A lost valid bit breaks the two-edge latency or the hold in the very next cycle.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    localparam int COMP_W      = 8;
    localparam int NUM_CH      = 3;
    localparam int FMT_BE_BIT  = 31;
    localparam int FMT_CNT_LSB = 3;
    localparam int FMT_CNT_W   = 3;

    typedef enum logic [1:0] {
        REG_FMT = 2'd0,
        REG_RED = 2'd1,
        REG_GRN = 2'd2,
        REG_BLU = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic [7:0] dflt;
        logic [7:0] width;
        logic [7:0] offset;
    } chan_sel_t;

    typedef struct packed {
        logic                 big_end;
        logic [FMT_CNT_W-1:0] cnt_m1;
    } pix_fmt_t;

    function automatic chan_sel_t sel_reset(int ch);
        chan_sel_t s;
        s.dflt   = 8'd0;
        s.width  = 8'd8;
        s.offset = 8'(ch * 8);
        return s;
    endfunction

endpackage

// File: rtl/pcx_cfg_regs.sv
module pcx_cfg_regs
    import pcx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [1:0]                    addr,
    input  logic [31:0]                   wdata,
    output pix_fmt_t                      fmt_o,
    output chan_sel_t [NUM_CH-1:0]        sel_o
);

    typedef struct packed {
        pix_fmt_t               fmt;
        chan_sel_t [NUM_CH-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (cfg_addr_e'(addr) == REG_FMT) begin
                cfg_d.fmt.big_end = wdata[FMT_BE_BIT];
                cfg_d.fmt.cnt_m1  = wdata[FMT_CNT_LSB +: FMT_CNT_W];
            end else begin
                cfg_d.sel[addr - 2'd1] = wdata[23:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.fmt.big_end <= 1'b0;
            cfg_q.fmt.cnt_m1  <= FMT_CNT_W'(3);
            for (int ch = 0; ch < NUM_CH; ch++) begin
                cfg_q.sel[ch] <= sel_reset(ch);
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fmt_o = cfg_q.fmt;
    assign sel_o = cfg_q.sel;

    // R10: a write lands in the register by the next edge
    a_r10_fmt_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd0) |=> (fmt_o.big_end == $past(wdata[FMT_BE_BIT])
                                  && fmt_o.cnt_m1 == $past(wdata[FMT_CNT_LSB +: FMT_CNT_W])))
        else $error("a_r10_fmt_write");

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel_chk
        a_r10_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == 2'(ch + 1)) |=> (sel_o[ch] == $past(wdata[23:0])))
            else $error("a_r10_sel_write");
    end

endmodule

// File: rtl/pcx_byte_order.sv
module pcx_byte_order
    import pcx_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic [WORD_BYTES*8-1:0] word_i,
    input  pix_fmt_t                fmt_i,
    output logic [WORD_BYTES*8-1:0] word_o
);

    localparam int WORD_W = WORD_BYTES * 8;
    localparam int CNT_W  = FMT_CNT_W + 1;

    logic [CNT_W-1:0] n_bytes;

    always_comb begin
        if (int'(fmt_i.cnt_m1) + 1 > WORD_BYTES) begin
            n_bytes = CNT_W'(WORD_BYTES);
        end else begin
            n_bytes = CNT_W'(fmt_i.cnt_m1) + CNT_W'(1);
        end
    end

    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_byte
        logic [CNT_W-1:0] src_be;
        logic [7:0]       pick_be;
        always_comb begin
            src_be  = n_bytes - CNT_W'(1) - CNT_W'(i);
            pick_be = '0;
            for (int k = 0; k < WORD_BYTES; k++) begin
                if (src_be == CNT_W'(k)) begin
                    pick_be = word_i[8*k +: 8];
                end
            end
        end
        assign word_o[8*i +: 8] = (CNT_W'(i) >= n_bytes) ? 8'd0 :
                                  (fmt_i.big_end ? pick_be : word_i[8*i +: 8]);
    end

    // R3: nothing past the configured byte count reaches the extractor
    always_comb begin
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (CNT_W'(i) >= n_bytes) begin
                a_r3_upper_zero: assert (word_o[8*i +: 8] == 8'd0)
                    else $error("a_r3_upper_zero");
            end
        end
    end

    logic unused_w;
    assign unused_w = ^{WORD_W'(0)};

endmodule

// File: rtl/pcx_chan_extract.sv
module pcx_chan_extract
    import pcx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_i,
    input  chan_sel_t         sel_i,
    output logic [COMP_W-1:0] comp_o
);

    logic [WORD_W-1:0] low_fld;
    logic [WORD_W-1:0] top_fld;
    logic [9:0]        top_sh;

    function automatic logic [7:0] widen(logic [6:0] f, logic [2:0] w);
        logic [7:0] r;
        case (w)
            3'd1:    r = {8{f[0]}};
            3'd2:    r = {4{f[1:0]}};
            3'd3:    r = {f[2:0], f[2:0], f[2:1]};
            3'd4:    r = {2{f[3:0]}};
            3'd5:    r = {f[4:0], f[4:2]};
            3'd6:    r = {f[5:0], f[5:4]};
            3'd7:    r = {f[6:0], f[6]};
            default: r = 8'd0;
        endcase
        return r;
    endfunction

    always_comb begin
        top_sh  = {2'b0, sel_i.offset} + {2'b0, sel_i.width} - 10'd8;
        low_fld = word_i >> sel_i.offset;
        top_fld = word_i >> top_sh;
        if (sel_i.width == 8'd0) begin
            comp_o = sel_i.dflt;
        end else if (sel_i.width >= 8'd8) begin
            comp_o = top_fld[7:0];
        end else begin
            comp_o = widen(low_fld[6:0], sel_i.width[2:0]);
        end
    end

endmodule

// File: rtl/pix_chan_unpack.sv
module pix_chan_unpack
    import pcx_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        pix_vld,
    input  logic [WORD_BYTES*8-1:0] pix_word,
    output logic        comp_vld,
    output logic [7:0]  comp_r,
    output logic [7:0]  comp_g,
    output logic [7:0]  comp_b
);

    localparam int WORD_W = WORD_BYTES * 8;

    typedef struct packed {
        logic                   vld;
        logic [WORD_W-1:0]      word;
        chan_sel_t [NUM_CH-1:0] sel;
    } stage1_t;

    typedef struct packed {
        logic                         vld;
        logic [NUM_CH-1:0][COMP_W-1:0] comp;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pix_fmt_t               fmt_q;
    chan_sel_t [NUM_CH-1:0] sel_q;
    logic [WORD_W-1:0]      ordered;
    logic [NUM_CH-1:0][COMP_W-1:0] comp_c;
    pipe_t                  pipe_d, pipe_q;

    pcx_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .fmt_o (fmt_q),
        .sel_o (sel_q)
    );

    pcx_byte_order #(.WORD_BYTES(WORD_BYTES)) u_order (
        .word_i (pix_word),
        .fmt_i  (fmt_q),
        .word_o (ordered)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pcx_chan_extract #(.WORD_W(WORD_W)) u_ext (
            .word_i (pipe_q.s1.word),
            .sel_i  (pipe_q.s1.sel[ch]),
            .comp_o (comp_c[ch])
        );
    end

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1.vld = pix_vld;
        if (pix_vld) begin
            pipe_d.s1.word = ordered;
            pipe_d.s1.sel  = sel_q;
        end
        pipe_d.s2.vld = pipe_q.s1.vld;
        if (pipe_q.s1.vld) begin
            pipe_d.s2.comp = comp_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign comp_vld = pipe_q.s2.vld;
    assign comp_r   = pipe_q.s2.comp[0];
    assign comp_g   = pipe_q.s2.comp[1];
    assign comp_b   = pipe_q.s2.comp[2];

    // R2: valid walks through both stages, one per edge
    a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> pipe_q.s1.vld) else $error("a_r2_enter");
    a_r2_leave: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld |=> comp_vld) else $error("a_r2_leave");
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.s1.vld |=> !comp_vld) else $error("a_r2_idle");

    // R11: no new result means no output movement
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.s1.vld |=> ($stable(comp_r) && $stable(comp_g) && $stable(comp_b)))
        else $error("a_r11_hold");

    // R10: the select copy only moves when a pixel is taken
    a_r10_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> $stable(pipe_q.s1.sel)) else $error("a_r10_snapshot");

    // R7: zero width passes the fallback value through
    a_r7_fallback_r: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.s1.vld && pipe_q.s1.sel[0].width == 8'd0) |=> comp_r == $past(pipe_q.s1.sel[0].dflt))
        else $error("a_r7_fallback_r");
    a_r7_fallback_g: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.s1.vld && pipe_q.s1.sel[1].width == 8'd0) |=> comp_g == $past(pipe_q.s1.sel[1].dflt))
        else $error("a_r7_fallback_g");
    a_r7_fallback_b: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.s1.vld && pipe_q.s1.sel[2].width == 8'd0) |=> comp_b == $past(pipe_q.s1.sel[2].dflt))
        else $error("a_r7_fallback_b");

endmodule

// File: tb/pix_chan_unpack_test.sv
module pix_chan_unpack_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        pix_vld;
    logic [31:0] pix_word;
    logic        comp_vld;
    logic [7:0]  comp_r, comp_g, comp_b;

    always #10 clk = ~clk;

    pix_chan_unpack uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pix_vld   (pix_vld),
        .pix_word  (pix_word),
        .comp_vld  (comp_vld),
        .comp_r    (comp_r),
        .comp_g    (comp_g),
        .comp_b    (comp_b)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    bit m_be;
    int m_cnt_m1;
    int m_off [3];
    int m_wid [3];
    int m_dfl [3];

    bit         a_v, b_v;
    logic [7:0] a_e [3];
    logic [7:0] b_e [3];
    logic [7:0] held [3];
    string      a_t, b_t;

    function automatic bit bit_at(logic [31:0] w, int idx);
        if (idx < 0 || idx > 31) return 1'b0;
        return w[idx];
    endfunction

    function automatic logic [7:0] model(logic [31:0] word, int ch);
        logic [31:0] w;
        logic [7:0]  r;
        int          n;
        n = m_cnt_m1 + 1;
        if (n > 4) n = 4;
        w = '0;
        for (int i = 0; i < n; i++) begin
            w[8*i +: 8] = m_be ? word[8*(n-1-i) +: 8] : word[8*i +: 8];
        end
        if (m_wid[ch] == 0) return 8'(m_dfl[ch]);
        for (int j = 0; j < 8; j++) begin
            if (m_wid[ch] >= 8)
                r[j] = bit_at(w, m_off[ch] + m_wid[ch] - 8 + j);
            else
                r[j] = bit_at(w, m_off[ch] + m_wid[ch] - 1 - ((7 - j) % m_wid[ch]));
        end
        return r;
    endfunction

    task automatic check1(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(bit pv, logic [31:0] pw, bit we, logic [1:0] ad,
                        logic [31:0] wd, string tag);
        @(negedge clk);
        check1("R2", "comp_vld", {7'd0, comp_vld}, {7'd0, b_v});
        if (b_v) begin
            check1(b_t, "red",   comp_r, b_e[0]);
            check1(b_t, "green", comp_g, b_e[1]);
            check1(b_t, "blue",  comp_b, b_e[2]);
            held = b_e;
        end else begin
            check1("R11", "red held",   comp_r, held[0]);
            check1("R11", "green held", comp_g, held[1]);
            check1("R11", "blue held",  comp_b, held[2]);
        end
        b_v = a_v;
        b_e = a_e;
        b_t = a_t;
        a_v = pv;
        a_t = tag;
        if (pv) begin
            for (int ch = 0; ch < 3; ch++) a_e[ch] = model(pw, ch);
        end
        if (we) begin
            if (ad == 2'd0) begin
                m_be     = wd[31];
                m_cnt_m1 = int'(wd[5:3]);
            end else begin
                m_off[ad-1] = int'(wd[7:0]);
                m_wid[ad-1] = int'(wd[15:8]);
                m_dfl[ad-1] = int'(wd[23:16]);
            end
        end
        pix_vld   = pv;
        pix_word  = pw;
        cfg_we    = we;
        cfg_addr  = ad;
        cfg_wdata = wd;
    endtask

    task automatic wr(logic [1:0] ad, logic [31:0] wd, string tag);
        step(1'b0, 32'd0, 1'b1, ad, wd, tag);
    endtask

    task automatic px(logic [31:0] pw, string tag);
        step(1'b1, pw, 1'b0, 2'd0, 32'd0, tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog expired actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int wsel;
        logic [31:0] wd;
        void'($urandom(32'd2718));
        m_be = 0; m_cnt_m1 = 3;
        for (int ch = 0; ch < 3; ch++) begin
            m_off[ch] = ch * 8; m_wid[ch] = 8; m_dfl[ch] = 0;
            a_e[ch] = 0; b_e[ch] = 0; held[ch] = 0;
        end
        a_v = 0; b_v = 0; a_t = "R1"; b_t = "R1";
        rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; pix_vld = 0; pix_word = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state at the ports
        check1("R1", "comp_vld", {7'd0, comp_vld}, 8'd0);
        check1("R1", "red",   comp_r, 8'd0);
        check1("R1", "green", comp_g, 8'd0);
        check1("R1", "blue",  comp_b, 8'd0);

        // R1 default layout
        px(32'h44332211, "R1");
        px(32'hF0E0D0C0, "R1");
        step(1'b0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'd0, "R11");
        step(1'b0, 32'h12345678, 1'b0, 2'd0, 32'd0, "R11");
        // R3 two-byte little-endian: byte 2 masked
        wr(2'd0, 32'h0000_0008, "R5");
        px(32'hAABBCCDD, "R3");
        // R4 four-byte big-endian
        wr(2'd0, 32'h8000_0018, "R5");
        px(32'h11223344, "R4");
        // R5 three-byte big-endian, and clamped count
        wr(2'd0, 32'h8000_0010, "R5");
        px(32'h99887766, "R5");
        wr(2'd0, 32'h0000_0038, "R5");
        px(32'h5566AA77, "R5");
        // R6 red moved to the top byte
        wr(2'd1, 32'h0000_0818, "R6");
        px(32'hC3000000, "R6");
        // R7 green disabled, fallback shown
        wr(2'd2, 32'h005A_0008, "R7");
        px(32'h12345678, "R7");
        // R8 four-bit and three-bit fields
        wr(2'd1, 32'h0000_0404, "R8");
        wr(2'd3, 32'h0000_0305, "R8");
        px(32'h000000A0, "R8");
        px(32'h000000E5, "R8");
        // R9 wide fields and fields past the word
        wr(2'd1, 32'h0000_0C14, "R9");
        wr(2'd3, 32'h0000_081C, "R9");
        px(32'hABCDEF01, "R9");
        // R10 write together with a pixel: that pixel keeps the old select
        step(1'b1, 32'h0F1E2D3C, 1'b1, 2'd2, 32'h0000_0800, "R10");
        px(32'h0F1E2D3C, "R10");
        step(1'b1, 32'h01020304, 1'b1, 2'd0, 32'h8000_0018, "R10");
        px(32'h01020304, "R10");

        // random traffic
        for (int it = 0; it < 4000; it++) begin
            wsel = $urandom_range(0, 3);
            wd   = $urandom;
            if (wsel != 0) begin
                case ($urandom_range(0, 3))
                    0:       wd[15:8] = 8'($urandom_range(0, 7));
                    1:       wd[15:8] = 8'd8;
                    2:       wd[15:8] = 8'($urandom_range(9, 16));
                    default: wd[15:8] = 8'($urandom_range(0, 40));
                endcase
                wd[7:0] = 8'($urandom_range(0, 40));
            end
            step($urandom_range(0, 3) != 0, $urandom, $urandom_range(0, 9) == 0,
                 2'(wsel), wd, "R9");
        end

        repeat (3) step(1'b0, 32'd0, 1'b0, 2'd0, 32'd0, "R11");
        done = 1;
        summary();
        $finish;
    end

endmodule